// File: doc/BRIEF.md
# Pipelined Burst SRAM with Zero-Turnaround Data Bus

This block is a synchronous static memory whose 36-bit word is made of four 9-bit byte lanes. A master starts a cycle with an active-low load strobe while the three chip selects are true. The block then captures the address and plays out a four-beat burst: one beat on the load clock and one on each of the next three enabled clocks that keep the strobe high. The low two address bits are the burst start. Each following beat is formed in linear order (start plus beat, modulo 4) or interleaved order (start XOR beat), chosen by a static order input.

Reads and writes travel through one two-stage pipeline. A command occupies the data bus in the same relative slot whether it reads or writes, so a read can follow a write, and a write can follow a read, with no idle clock. A read that meets a write still in flight on the bus returns the new lane data. An active-low clock enable freezes every register, and an output-enable input gates the bus driver combinationally. The bus is split into input data, output data and a drive-enable for tri-state pads.

A sequencer state machine has three states. ST_IDLE means no burst is active. ST_RD means a read burst is active and ST_WR means a write burst is active. Its transitions are:
- load-read and load-write go into ST_RD or ST_WR.
- deselect goes to ST_IDLE.
- advance stays in the burst state and steps the beat.
- burst-end leaves ST_RD or ST_WR after the fourth beat.
- rejected-load holds the current state.

Top module: `burst_sram`

## Requirements
- R1: After reset, `dq_oe` and `load_err` are low and no burst is active.
- R2: On an enabled clock with `load_n` low and all selects true (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0), `rd_wr`=1 starts a read burst and `rd_wr`=0 starts a write burst at the captured `addr`.
- R3: A load with any select false is a deselect. It issues no access, ends any active burst, writes nothing to the array and leaves the bus undriven in its slot.
- R4: Each enabled clock with `load_n` high during a burst issues the next beat, up to four beats in total. An advance after the fourth beat issues nothing and ends the burst.
- R5: With `order_il`=0, beat n accesses address bits [1:0] = (start + n) mod 4. The upper bits stay those captured at load.
- R6: With `order_il`=1, beat n accesses address bits [1:0] = start XOR n.
- R7: Each access owns the bus in the cycle that ends at the second enabled clock after its command clock. A read drives `dq_out` with `dq_oe` high in that cycle. A write takes `dq_in` and `lane_wr_n` at that clock. Read and write bursts may follow each other with no gap.
- R8: Lane i is `dq_in`/`dq_out` bits [9i+8:9i]. `lane_wr_n[i]`=0 writes the lane and 1 keeps the old contents. `lane_wr_n` and `dq_in` have no effect in read, deselect or idle slots.
- R9: A read whose command follows a write command to the same address on the previous enabled clock returns the written lanes merged with the array's unmasked lanes.
- R10: While `clk_en_n` is high, no state, output register or array word changes. A pending access completes after the enable returns.
- R11: `out_en_n` high forces `dq_oe` low in the same cycle, and `dq_oe` is low in write, deselect and idle slots.
- R12: A load on the enabled clock right after a load raises `load_err` until the next enabled clock. That load is ignored, and an active burst continues unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| load_n | input | 1 | Active-low load strobe; high advances a burst |
| rd_wr | input | 1 | 1 = read, 0 = write, used on load |
| order_il | input | 1 | Static burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address captured on load |
| lane_wr_n | input | LANES | Active-low byte-lane write enables, sampled in the write slot |
| dq_in | input | LANES*LANE_W | Write data, sampled in the write slot |
| out_en_n | input | 1 | Active-low output enable, combinational |
| dq_out | output | LANES*LANE_W | Read data |
| dq_oe | output | 1 | Drive enable for the data bus |
| load_err | output | 1 | Back-to-back load flag |

## Verification
The risky coincidence is a write retiring into the array on the same clock edge that loads a read of that address into the output register. The bench provokes it by starting a read burst on the clock right after a write burst's last beat, with the read's first beat on that last address. It does this with full lane masks and with partial ones, and judges the returned word against a reference memory updated lane by lane. The clock-enable stall is also laid over the same turnaround: stalls are inserted between load and advance clocks of both read and write bursts. The bench then checks that the bus slots shift by exactly the stalled cycles and that the stalled write lands once.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } seq_state_t;

    // Low address bits of a burst beat for the selected order.
    function automatic logic [1:0] beat_lsb(
        input logic [1:0] start,
        input logic [1:0] beat,
        input logic       interleaved
    );
        logic [1:0] r;
        if (interleaved) r = start ^ beat;
        else             r = start + beat;
        return r;
    endfunction

endpackage

// File: rtl/burst_seq.sv
module burst_seq
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load_n,
    input  logic              rd_wr,
    input  logic              chip_sel,
    input  logic              order_il,
    input  logic [ADDR_W-1:0] addr,
    output logic              cmd_v,
    output logic              cmd_we,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              load_err,
    output logic [1:0]        beat,
    output logic              busy
);

    seq_state_t        st_q, st_d;
    logic [1:0]        beat_q, beat_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic              prev_load_q;
    logic              load_req, bad_load;
    logic              iss, iss_we;
    logic [ADDR_W-1:0] iss_addr;
    logic [1:0]        nxt_beat;

    assign load_req = !load_n;
    assign bad_load = load_req && prev_load_q;
    assign nxt_beat = beat_q + 2'd1;

    // Next-state and issue decode.
    always_comb begin
        st_d     = st_q;
        beat_d   = beat_q;
        base_d   = base_q;
        iss      = 1'b0;
        iss_we   = 1'b0;
        iss_addr = base_q;
        if (bad_load) begin
            // rejected-load: hold everything
        end else if (load_req) begin
            if (chip_sel) begin
                st_d     = rd_wr ? ST_RD : ST_WR;
                beat_d   = 2'd0;
                base_d   = addr;
                iss      = 1'b1;
                iss_we   = !rd_wr;
                iss_addr = addr;
            end else begin
                st_d = ST_IDLE;
            end
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                end
                ST_RD, ST_WR: begin
                    if (beat_q == 2'd3) begin
                        st_d = ST_IDLE;
                    end else begin
                        beat_d   = nxt_beat;
                        iss      = 1'b1;
                        iss_we   = (st_q == ST_WR);
                        iss_addr = {base_q[ADDR_W-1:2],
                                    beat_lsb(base_q[1:0], nxt_beat, order_il)};
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            beat_q      <= 2'd0;
            base_q      <= '0;
            prev_load_q <= 1'b0;
        end else if (en) begin
            st_q        <= st_d;
            beat_q      <= beat_d;
            base_q      <= base_d;
            prev_load_q <= load_req;
        end
    end

    // Registered outputs: first pipeline stage and error flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_v    <= 1'b0;
            cmd_we   <= 1'b0;
            cmd_addr <= '0;
            load_err <= 1'b0;
        end else if (en) begin
            cmd_v    <= iss;
            cmd_we   <= iss_we;
            cmd_addr <= iss_addr;
            load_err <= bad_load;
        end
    end

    assign beat = beat_q;
    assign busy = (st_q != ST_IDLE);

endmodule

// File: rtl/burst_pipe.sv
module burst_pipe #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    s1_v,
    input  logic                    s1_we,
    input  logic [ADDR_W-1:0]       s1_addr,
    input  logic [LANES*LANE_W-1:0] rd_word,
    input  logic [LANES*LANE_W-1:0] dq_in,
    input  logic [LANES-1:0]        lane_wr_n,
    output logic [LANES-1:0]        wr_lane,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [LANES*LANE_W-1:0] q,
    output logic                    drv
);

    localparam int DATA_W = LANES * LANE_W;

    logic              s2_v, s2_we;
    logic [ADDR_W-1:0] s2_addr;
    logic [DATA_W-1:0] merged;
    logic              s2_write, s1_read;

    assign s2_write = s2_v && s2_we;
    assign s1_read  = s1_v && !s1_we;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic fwd;
        assign fwd = s2_write && (s2_addr == s1_addr) && !lane_wr_n[i];
        assign merged[i*LANE_W +: LANE_W] = fwd ? dq_in[i*LANE_W +: LANE_W]
                                                : rd_word[i*LANE_W +: LANE_W];
        assign wr_lane[i] = en && s2_write && !lane_wr_n[i];
    end

    assign wr_addr = s2_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_v    <= 1'b0;
            s2_we   <= 1'b0;
            s2_addr <= '0;
            drv     <= 1'b0;
            q       <= '0;
        end else if (en) begin
            s2_v    <= s1_v;
            s2_we   <= s1_we;
            s2_addr <= s1_addr;
            drv     <= s1_read;
            if (s1_read) q <= merged;
        end
    end

endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        wr_lane,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar i = 0; i < LANES; i++) begin : g_bank
        logic [LANE_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_lane[i]) mem[wr_addr] <= wr_data[i*LANE_W +: LANE_W];
        end
        assign rd_data[i*LANE_W +: LANE_W] = mem[rd_addr];
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    load_n,
    input  logic                    rd_wr,
    input  logic                    order_il,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [LANES*LANE_W-1:0] dq_in,
    input  logic                    out_en_n,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_oe,
    output logic                    load_err
);

    localparam int DATA_W = LANES * LANE_W;

    logic              en, chip_sel;
    logic              s1_v, s1_we, drv, busy;
    logic [1:0]        beat;
    logic [ADDR_W-1:0] s1_addr, wr_addr;
    logic [LANES-1:0]  wr_lane;
    logic [DATA_W-1:0] rd_word;

    assign en       = !clk_en_n;
    assign chip_sel = !sel_a_n && sel_b && !sel_c_n;

    burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .load_n   (load_n),
        .rd_wr    (rd_wr),
        .chip_sel (chip_sel),
        .order_il (order_il),
        .addr     (addr),
        .cmd_v    (s1_v),
        .cmd_we   (s1_we),
        .cmd_addr (s1_addr),
        .load_err (load_err),
        .beat     (beat),
        .busy     (busy)
    );

    sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .wr_lane (wr_lane),
        .wr_addr (wr_addr),
        .wr_data (dq_in),
        .rd_addr (s1_addr),
        .rd_data (rd_word)
    );

    burst_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .s1_v      (s1_v),
        .s1_we     (s1_we),
        .s1_addr   (s1_addr),
        .rd_word   (rd_word),
        .dq_in     (dq_in),
        .lane_wr_n (lane_wr_n),
        .wr_lane   (wr_lane),
        .wr_addr   (wr_addr),
        .q         (dq_out),
        .drv       (drv)
    );

    assign dq_oe = drv && !out_en_n;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en_n,
    input logic              load_n,
    input logic              out_en_n,
    input logic              chip_sel,
    input logic              cmd_v,
    input logic              cmd_we,
    input logic              load_err,
    input logic              dq_oe,
    input logic [DATA_W-1:0] dq_out,
    input logic [1:0]        beat,
    input logic              busy
);

    logic prev_load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         prev_load <= 1'b0;
        else if (!clk_en_n) prev_load <= !load_n;
    end

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(load_err) && $stable(dq_out) && $stable(beat)));

    // R12
    bad_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !load_n && prev_load) |=> load_err);

    // R3
    desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !load_n && !prev_load && !chip_sel) |=> (!cmd_v && !busy));

    // R4
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && load_n && busy && beat != 2'd3) |=> (beat == $past(beat) + 2'd1));

    // R7
    slot_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && cmd_v) |=> (dq_oe == (!$past(cmd_we) && !out_en_n)));

endmodule

bind burst_sram burst_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_n (clk_en_n),
    .load_n   (load_n),
    .out_en_n (out_en_n),
    .chip_sel (chip_sel),
    .cmd_v    (s1_v),
    .cmd_we   (s1_we),
    .load_err (load_err),
    .dq_oe    (dq_oe),
    .dq_out   (dq_out),
    .beat     (beat),
    .busy     (busy)
);

// File: tb/burst_sram_tb.sv
`timescale 1ns/1ps
module burst_sram_tb;

    localparam int AW = 6, LN = 4, LW = 9, DW = LN * LW, DEPTH = 1 << AW;

    logic clk = 0, rst_n = 0, clk_en_n = 0;
    logic sel_a_n = 0, sel_b = 1, sel_c_n = 0;
    logic load_n = 1, rd_wr = 1, order_il = 0, out_en_n = 0;
    logic [AW-1:0] addr = '0;
    logic [LN-1:0] lane_wr_n = '1;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic dq_oe, load_err;

    always #2.5 clk = ~clk;

    burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .load_n(load_n), .rd_wr(rd_wr), .order_il(order_il), .addr(addr),
        .lane_wr_n(lane_wr_n), .dq_in(dq_in), .out_en_n(out_en_n),
        .dq_out(dq_out), .dq_oe(dq_oe), .load_err(load_err)
    );

    int errs = 0, checks = 0, seed = 0, cyc = 0;
    bit il = 0;
    logic [DW-1:0] ref_mem [DEPTH];

    // Reference burst model and two-slot pipeline.
    int m_st = 0, m_beat = 0, m_base = 0;
    bit m_prev = 0, exp_err = 0;
    bit p0_v = 0, p0_w = 0, p1_v = 0, p1_w = 0;
    int p0_a = 0, p1_a = 0;
    logic [DW-1:0] p0_d = '0, p1_d = '0;
    logic [LN-1:0] p0_m = '1, p1_m = '1;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errs++;
            $display("FAIL watchdog: actual cycles=%0d expected below 100000", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    function automatic logic [DW-1:0] wdat(int a);
        logic [31:0] h;
        h = 32'(a) * 32'h9E3779B1 + 32'(seed) * 32'h1F123BB5;
        return {4'(a), h};
    endfunction

    task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive inputs, model the edge, then check the bus slot.
    task automatic step(bit ld, bit rw, int cs, int a, bit stall, bit oen,
                        logic [LN-1:0] wm, string tag);
        bit nv = 0, nw = 0, ne = 0;
        int na = 0;
        bit exp_oe;
        load_n   = !ld;
        rd_wr    = rw;
        sel_a_n  = (cs == 1);
        sel_b    = (cs != 2);
        sel_c_n  = (cs == 3);
        addr     = AW'(a);
        clk_en_n = stall;
        out_en_n = oen;
        order_il = il;
        if (!stall) begin
            ne = ld && m_prev;
            if (ne) begin
            end else if (ld) begin
                if (cs == 0) begin
                    m_st = rw ? 1 : 2; m_beat = 0; m_base = a;
                    nv = 1; nw = !rw; na = a;
                end else m_st = 0;
            end else if (m_st != 0) begin
                if (m_beat == 3) m_st = 0;
                else begin
                    m_beat++;
                    nv = 1; nw = (m_st == 2);
                    na = (m_base & ~3) | (il ? ((m_base & 3) ^ m_beat)
                                             : ((m_base + m_beat) & 3));
                end
            end
            m_prev = ld;
        end
        @(posedge clk);
        @(negedge clk);
        if (!stall) begin
            p1_v = p0_v; p1_w = p0_w; p1_a = p0_a; p1_d = p0_d; p1_m = p0_m;
            p0_v = nv; p0_w = nw; p0_a = na; p0_d = wdat(na); p0_m = wm;
            exp_err = ne;
        end
        chk(load_err == exp_err, "R12 load_err", DW'(load_err), DW'(exp_err));
        exp_oe = p1_v && !p1_w && !oen;
        chk(dq_oe == exp_oe, {tag, " R11 dq_oe"}, DW'(dq_oe), DW'(exp_oe));
        if (exp_oe)
            chk(dq_out == ref_mem[p1_a], {tag, " R7 read data"}, dq_out, ref_mem[p1_a]);
        if (p1_v && p1_w) begin
            dq_in = p1_d;
            lane_wr_n = p1_m;
            for (int i = 0; i < LN; i++)
                if (!p1_m[i]) ref_mem[p1_a][i*LW +: LW] = p1_d[i*LW +: LW];
        end else begin
            dq_in = {DW{1'b1}} ^ DW'(seed * 977 + cyc);
            lane_wr_n = '0;
        end
    endtask

    task automatic burst(bit rw, int a, logic [15:0] ms, string tag);
        step(1, rw, 0, a, 0, 0, ms[3:0], tag);
        for (int b = 1; b < 4; b++) step(0, rw, 0, 0, 0, 0, ms[b*4 +: 4], tag);
    endtask

    task automatic idle(int n, string tag);
        for (int k = 0; k < n; k++) step(0, 1, 0, 0, 0, 0, 4'hF, tag);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(dq_oe == 1'b0, "R1 reset dq_oe", DW'(dq_oe), '0);
        chk(load_err == 1'b0, "R1 reset load_err", DW'(load_err), '0);

        // R2: fill the whole array with back-to-back write bursts
        seed = 1; il = 0;
        for (int b = 0; b < DEPTH / 4; b++) burst(0, b * 4, 16'h0000, "R2 fill");
        idle(2, "R4 burst end");

        // R5: linear reads, every start offset
        for (int b = 0; b < DEPTH / 4; b++) burst(1, b * 4 + (b % 4), 16'h0, "R5 linear");
        idle(2, "R4 burst end");

        // R6: interleaved reads, every start offset
        il = 1;
        for (int b = 0; b < DEPTH / 4; b++) burst(1, b * 4 + ((b + 1) % 4), 16'h0, "R6 interleaved");
        idle(2, "R4 burst end");
        il = 0;

        // R7/R9: no-gap turnaround, read of the last written beat
        seed = 2;
        burst(0, 8, 16'h0, "R7 write");
        burst(1, 11, 16'h0, "R9 forward");
        burst(0, 12, 16'h0, "R7 read-to-write");
        burst(1, 12, 16'h0, "R7 readback");
        idle(2, "R4 burst end");

        // R8: every lane mask value, then read back
        seed = 3;
        for (int k = 0; k < 4; k++)
            burst(0, 24 + 4 * k, {4'(4*k+3), 4'(4*k+2), 4'(4*k+1), 4'(4*k)}, "R8 mask");
        for (int k = 0; k < 4; k++) burst(1, 24 + 4 * k, 16'h0, "R8 mask readback");
        seed = 4;
        burst(0, 20, 16'hA5C3, "R8 partial");
        burst(1, 23, 16'h0, "R9 merge");
        idle(2, "R4 burst end");

        // R3: deselect through each chip select, then mid-burst
        seed = 5;
        for (int cs = 1; cs < 4; cs++) begin
            step(1, 0, cs, 40, 0, 0, 4'h0, "R3 deselect");
            for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 0, 4'h0, "R3 idle");
        end
        burst(1, 40, 16'h0, "R3 readback");
        step(1, 1, 0, 44, 0, 0, 4'h0, "R3 start");
        step(0, 1, 0, 0, 0, 0, 4'h0, "R3 beat");
        step(1, 1, 2, 44, 0, 0, 4'h0, "R3 end burst");
        for (int k = 0; k < 3; k++) step(0, 1, 0, 0, 0, 0, 4'h0, "R3 after");

        // R10: stalls inside read and write bursts
        seed = 6;
        step(1, 1, 0, 4, 0, 0, 4'h0, "R10 read");
        step(0, 1, 0, 0, 1, 0, 4'h0, "R10 stall");
        step(0, 1, 0, 0, 0, 0, 4'h0, "R10 read");
        step(0, 1, 0, 0, 1, 0, 4'h0, "R10 stall");
        step(0, 1, 0, 0, 1, 0, 4'h0, "R10 stall");
        step(0, 1, 0, 0, 0, 0, 4'h0, "R10 read");
        step(0, 1, 0, 0, 1, 0, 4'h0, "R10 stall");
        step(0, 1, 0, 0, 0, 0, 4'h0, "R10 read");
        step(1, 0, 0, 48, 0, 0, 4'h0, "R10 write");
        step(0, 0, 0, 0, 1, 0, 4'h0, "R10 stall");
        step(0, 0, 0, 0, 0, 0, 4'h6, "R10 write");
        step(0, 0, 0, 0, 1, 0, 4'h0, "R10 stall");
        step(0, 0, 0, 0, 0, 0, 4'h0, "R10 write");
        step(0, 0, 0, 0, 0, 0, 4'h9, "R10 write");
        step(0, 0, 0, 0, 1, 0, 4'h0, "R10 stall");
        step(0, 0, 0, 0, 1, 0, 4'h0, "R10 stall");
        idle(3, "R10 drain");
        burst(1, 48, 16'h0, "R10 readback");

        // R11: output enable gating in read slots
        step(1, 1, 0, 0, 0, 0, 4'h0, "R11 oe");
        step(0, 1, 0, 0, 0, 0, 4'h0, "R11 oe");
        step(0, 1, 0, 0, 0, 1, 4'h0, "R11 oe off");
        step(0, 1, 0, 0, 0, 1, 4'h0, "R11 oe off");
        step(0, 1, 0, 0, 0, 0, 4'h0, "R11 oe");
        idle(2, "R11 tail");

        // R12: back-to-back load, second one (a write) ignored
        seed = 7;
        step(1, 1, 0, 52, 0, 0, 4'h0, "R12 first load");
        step(1, 0, 0, 0, 0, 0, 4'h0, "R12 rejected load");
        for (int k = 0; k < 4; k++) step(0, 1, 0, 0, 0, 0, 4'h0, "R12 continue");
        idle(2, "R12 tail");

        // R8: final sweep proves no stray writes anywhere
        for (int b = 0; b < DEPTH / 4; b++) burst(1, b * 4, 16'h0, "R8 final");
        idle(2, "R4 burst end");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule